// File: doc/BRIEF.md
# Synchronous Up/Down Decimal Digit Counter

This block holds one decimal digit in a four-bit register and counts up or down through the values 0 to 9, changing state only on the rising clock edge. A synchronous load copies a four-bit data word into the register and takes priority over counting. Two active-low enables must both be low for a count to happen. The first enable is local to the stage. The second enable is chained from the stage below.

An active-low terminal-count output is decoded from the register, the direction and the chained enable. Feeding it into the chained enable of the next stage gives a multi-digit counter that wraps as a whole. Loads and power-up can leave the register holding a code from 10 to 15. The next-state rules bring any such code back to a digit within two counted edges. A synchronous active-high reset clears the digit for initialisation.

Top module: `bcd_updn_ctr`

## Requirements
- R1: With `srst` high at a rising edge, `q` becomes 0 on that edge, whatever the other inputs are.
- R2: With `srst` low and `load_n` low at a rising edge, `q` takes the value of `din` on that edge, whatever `en_par_n`, `en_chain_n` and `up` are.
- R3: With `srst` and `load_n` both high, `q` keeps its value whenever `en_par_n` or `en_chain_n` is high.
- R4: A count happens when `srst` is low, `load_n` is high and both enables are low. With `up` high, a count moves `q` from n to n+1 for n from 0 to 8, and from 9 to 0.
- R5: During a count with `up` low, `q` moves from n to n-1 for n from 1 to 9, and from 0 to 9.
- R6: With `up` high and `en_chain_n` low, `tc_n` is low exactly when `q[0]` and `q[3]` are both 1. These are the codes 9, 11, 13 and 15. Otherwise `tc_n` is high.
- R7: With `up` low and `en_chain_n` low, `tc_n` is low exactly when `q` is 0.
- R8: `tc_n` is high whenever `en_chain_n` is high, and it does not depend on `en_par_n`.
- R9: Counting up from an out-of-range code moves 10, 12 and 14 to 11, 13 and 15 respectively, and moves 11, 13 and 15 to 0. Every out-of-range code therefore reaches a digit within two counts.
- R10: Counting down from any code from 10 to 15 gives 9.
- R11: Two stages share the local enable and direction. The lower stage's `tc_n` drives the upper stage's `en_chain_n`. Chained this way, they count 00 to 99 and wrap to 00 going up, and count 99 to 00 and wrap to 99 going down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| srst | input | 1 | Synchronous reset to 0, active high |
| load_n | input | 1 | Synchronous load of `din`, active low |
| en_par_n | input | 1 | Local count enable, active low |
| en_chain_n | input | 1 | Chained count enable, active low, also gates `tc_n` |
| up | input | 1 | Direction: 1 increments, 0 decrements |
| din | input | 4 | Data loaded into the register |
| q | output | 4 | Current count |
| tc_n | output | 1 | Terminal count, active low, combinational |

## Verification
A load and a count can be requested on the same edge, and so can a reset and a load. The bench provokes both collisions by holding both enables low while pulsing `load_n`, and by asserting `srst` with `load_n` low. The outcome is judged against the priority order: reset first, then load, then count. A behavioural reference model of two chained digits is compared with both stages and both terminal-count outputs on every clock. That comparison covers the clock where the lower digit wraps and the upper digit counts on the same edge.

// File: rtl/bcd_updn_ctr.sv
module bcd_updn_ctr (
  input  logic       clk,
  input  logic       srst,
  input  logic       load_n,
  input  logic       en_par_n,
  input  logic       en_chain_n,
  input  logic       up,
  input  logic [3:0] din,
  output logic [3:0] q,
  output logic       tc_n
);

  localparam logic [3:0] TOP = 4'd9;

  logic       count;
  logic       up_end;
  logic       dn_end;
  logic [3:0] nxt_up;
  logic [3:0] nxt_dn;

  assign count  = load_n & ~en_par_n & ~en_chain_n;
  assign up_end = q[3] & q[0];
  assign dn_end = (q == 4'd0);

  assign nxt_up = up_end ? 4'd0 : q + 4'd1;
  assign nxt_dn = (dn_end || q > TOP) ? TOP : q - 4'd1;

  assign tc_n = ~(~en_chain_n & (up ? up_end : dn_end));

  always_ff @(posedge clk) begin
    if (srst)         q <= 4'd0;
    else if (!load_n) q <= din;
    else if (count)   q <= up ? nxt_up : nxt_dn;
  end

endmodule

module bcd_updn_ctr_chk (
  input logic       clk,
  input logic       srst,
  input logic       load_n,
  input logic       en_par_n,
  input logic       en_chain_n,
  input logic       up,
  input logic [3:0] din,
  input logic [3:0] q,
  input logic       tc_n
);

  logic cnt;
  assign cnt = load_n && !en_par_n && !en_chain_n;

  AST_RESET_CLEARS: assert property (@(posedge clk) srst |=> q == 4'd0); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (srst) !load_n |=> q == $past(din)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (srst) (load_n && (en_par_n || en_chain_n)) |=> $stable(q)); // R3
  AST_UP_STEP: assert property (@(posedge clk) disable iff (srst) (cnt && up && q < 4'd9) |=> q == $past(q) + 4'd1); // R4
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (srst) (cnt && up && q == 4'd9) |=> q == 4'd0); // R4
  AST_DN_STEP: assert property (@(posedge clk) disable iff (srst) (cnt && !up && q != 4'd0 && q <= 4'd9) |=> q == $past(q) - 4'd1); // R5
  AST_DN_WRAP: assert property (@(posedge clk) disable iff (srst) (cnt && !up && q == 4'd0) |=> q == 4'd9); // R5
  AST_TC_GATED: assert property (@(posedge clk) disable iff (srst) en_chain_n |-> tc_n); // R8
  AST_TC_DOWN: assert property (@(posedge clk) disable iff (srst) (!en_chain_n && !up) |-> (tc_n == (q != 4'd0))); // R7
  AST_ILL_UP_EVEN: assert property (@(posedge clk) disable iff (srst) (cnt && up && q > 4'd9 && !q[0]) |=> q == $past(q) + 4'd1); // R9
  AST_ILL_UP_ODD: assert property (@(posedge clk) disable iff (srst) (cnt && up && q > 4'd9 && q[0]) |=> q == 4'd0); // R9
  AST_ILL_DOWN: assert property (@(posedge clk) disable iff (srst) (cnt && !up && q > 4'd9) |=> q == 4'd9); // R10

endmodule

bind bcd_updn_ctr bcd_updn_ctr_chk chk_i (
  .clk(clk), .srst(srst), .load_n(load_n), .en_par_n(en_par_n),
  .en_chain_n(en_chain_n), .up(up), .din(din), .q(q), .tc_n(tc_n)
);

// File: tb/bcd_updn_ctr_tb.sv
`timescale 1ns/1ps
module bcd_updn_ctr_tb_top;

  logic       clk = 1'b0;
  logic       srst = 1'b1;
  logic       load_n = 1'b1;
  logic       en_p_n = 1'b1;
  logic       en_c_n = 1'b1;
  logic       up = 1'b1;
  logic [3:0] din_lo = 4'd0;
  logic [3:0] din_hi = 4'd0;
  logic [3:0] q_lo, q_hi;
  logic       tc_lo_n, tc_hi_n;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string tag = "R1";
  int    m_lo = 0, m_hi = 0;

  always #2 clk = ~clk;

  bcd_updn_ctr dut_i (
    .clk(clk), .srst(srst), .load_n(load_n), .en_par_n(en_p_n),
    .en_chain_n(en_c_n), .up(up), .din(din_lo), .q(q_lo), .tc_n(tc_lo_n)
  );

  bcd_updn_ctr dut_hi (
    .clk(clk), .srst(srst), .load_n(load_n), .en_par_n(en_p_n),
    .en_chain_n(tc_lo_n), .up(up), .din(din_hi), .q(q_hi), .tc_n(tc_hi_n)
  );

  function automatic int step(int v, bit dir_up);
    if (dir_up) return (v == 9 || v == 11 || v == 13 || v == 15) ? 0 : v + 1;
    return (v == 0 || v > 9) ? 9 : v - 1;
  endfunction

  function automatic bit term(int v, bit dir_up, bit chain_n);
    if (chain_n) return 1'b1;
    if (dir_up) return !(v == 9 || v == 11 || v == 13 || v == 15);
    return !(v == 0);
  endfunction

  always @(posedge clk) begin
    bit lo_tc;
    lo_tc = term(m_lo, up, en_c_n);
    if (srst) begin
      m_lo = 0; m_hi = 0;
    end else if (!load_n) begin
      m_lo = din_lo; m_hi = din_hi;
    end else begin
      if (!en_p_n && !lo_tc) m_hi = step(m_hi, up);
      if (!en_p_n && !en_c_n) m_lo = step(m_lo, up);
    end
    cycles++;
  end

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit lo_tc;
    lo_tc = term(m_lo, up, en_c_n);
    chk(tag, int'(q_lo), m_lo);
    chk(tag, int'(q_hi), m_hi);
    chk(tag, int'(tc_lo_n), int'(lo_tc));
    chk(tag, int'(tc_hi_n), int'(term(m_hi, up, lo_tc)));
  end

  task automatic drive(bit rs, bit ld, bit ep, bit ec, bit u, int dl, int dh);
    @(posedge clk);
    #1;
    srst = rs; load_n = ld; en_p_n = ep; en_c_n = ec; up = u;
    din_lo = 4'(dl); din_hi = 4'(dh);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 50000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <50000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    tag = "R1";
    drive(1, 0, 0, 0, 1, 7, 3);
    drive(1, 1, 0, 0, 1, 0, 0);
    drive(0, 1, 1, 1, 1, 0, 0);
    tag = "R2";
    drive(0, 0, 0, 0, 1, 5, 2);
    drive(0, 0, 1, 1, 0, 8, 6);
    drive(0, 0, 0, 1, 1, 14, 9);
    tag = "R3";
    drive(0, 1, 1, 0, 1, 0, 0);
    drive(0, 1, 0, 1, 0, 0, 0);
    drive(0, 1, 1, 1, 1, 0, 0);
    tag = "R8";
    drive(0, 0, 1, 1, 1, 9, 9);
    drive(0, 1, 1, 0, 1, 0, 0);
    drive(0, 1, 1, 1, 1, 0, 0);
    drive(0, 1, 1, 0, 0, 0, 0);
    tag = "R4 R6 R11";
    drive(0, 0, 1, 1, 1, 0, 0);
    for (int i = 0; i < 102; i++) drive(0, 1, 0, 0, 1, 0, 0);
    tag = "R5 R7 R11";
    for (int i = 0; i < 102; i++) drive(0, 1, 0, 0, 0, 0, 0);
    tag = "R2 load over count";
    drive(0, 0, 0, 0, 1, 4, 7);
    drive(0, 1, 0, 0, 1, 0, 0);
    for (int c = 10; c < 16; c++) begin
      tag = "R6 R9";
      drive(0, 0, 1, 1, 1, c, c);
      drive(0, 1, 0, 0, 1, 0, 0);
      drive(0, 1, 0, 0, 1, 0, 0);
      drive(0, 1, 1, 1, 1, 0, 0);
      @(negedge clk);
      chk("R9 legal after two", int'(q_lo <= 4'd9), 1);
      tag = "R10";
      drive(0, 0, 1, 1, 0, c, c);
      drive(0, 1, 0, 0, 0, 0, 0);
      drive(0, 1, 1, 1, 0, 0, 0);
      @(negedge clk);
      chk("R10 down to 9", int'(q_lo), 9);
    end
    tag = "R1";
    drive(1, 0, 0, 0, 0, 6, 6);
    drive(0, 1, 1, 1, 1, 0, 0);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule